// File: doc/BRIEF.md
# Linked Descriptor Chain Walker

This block moves a series of buffers without help from software. Each buffer is described by a three-word record held in memory. Software builds a linked list of these records and writes the address of the first one to the start register. The engine then reads each record through a single-word memory read port. It checks the data address and hands a command to an external data mover. The command carries the buffer address, the byte count, the transfer direction and the lane mode. When the mover reports that it has finished, the engine follows the link to the next record, or stops.

A record with its continuation flag set must carry a valid link, and the engine goes on to fetch the linked record. A record with the flag clear ends the chain. A single completion bit is raised for the whole chain, not one per buffer. A buffer address that is not aligned to the required boundary halts the walk and raises an error bit instead. Two registers expose progress. One holds the address of the record being handled. The other holds a memory address that starts at the buffer address and advances with each word the mover reports.

Top module: `desc_chain_engine`

## Requirements
- R1: While idle, a start write loads the current-record register with the written address and begins fetching. On the next cycle `busy` and `mem_req` are high and `mem_addr` equals that address. The three record words are then read at that address, +4 and +8.
- R2: Word 0 of a record is the buffer address and word 1 is the link address. Word 2 is the control word: direction in bit 0, lane mode in bits 3:1, continuation flag in bit 8 and byte count in bits 31:16. The command passes on the buffer address, count, direction and mode unchanged.
- R3: A buffer address whose low ALIGN_BITS (default 5) bits are not all zero issues no command for that record. It sets status bit 3 and returns the engine to idle. No later record is fetched.
- R4: When the mover reports done for a record whose continuation flag is set, the current-record register takes the link address and the next record is fetched from it.
- R5: When the mover reports done for a record whose continuation flag is clear, status bit 31 is set and the engine returns to idle. Bits 31 and 3 never rise in the same cycle.
- R6: The current-memory-address register loads the buffer address when a command is issued. It grows by BEAT_BYTES (default 4) for every mover beat pulse.
- R7: A start write while `busy` is high is ignored: the current-record register and the walk of the chain are unaffected.
- R8: Status bits are cleared by writing ones to `status_clr`, and only the bits written are cleared. `irq` is high whenever any status bit is set.
- R9: After reset, `busy`, `irq`, `status`, `mem_req`, `cmd_valid` and both progress registers are zero.
- R10: `mem_req` stays high with `mem_addr` stable until `mem_rvalid`. `cmd_valid` stays high with its fields stable until `cmd_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_we | input | 1 | Write strobe for the start (first record) address |
| start_addr | input | 32 | Address of the first record |
| mem_req | output | 1 | Record word read request |
| mem_addr | output | 32 | Byte address of the requested record word |
| mem_rvalid | input | 1 | Read data valid for the pending request |
| mem_rdata | input | 32 | Read data |
| cmd_valid | output | 1 | Command to the data mover is valid |
| cmd_ready | input | 1 | Mover accepts the command |
| cmd_addr | output | 32 | Buffer address |
| cmd_len | output | 16 | Byte count |
| cmd_dir | output | 1 | Direction (0 read from device, 1 write to device) |
| cmd_mode | output | 3 | Lane mode code |
| mv_beat | input | 1 | Mover moved one word |
| mv_done | input | 1 | Mover finished the current command |
| cur_desc_addr | output | 32 | Address of the record being handled |
| cur_mem_addr | output | 32 | Running memory address of the current buffer |
| busy | output | 1 | A chain is being walked |
| status | output | 32 | Interrupt status (bit 31 chain done, bit 3 address error) |
| status_clr | input | 32 | Write-one-to-clear mask for `status` |
| irq | output | 1 | Any status bit set |

## Verification
Every cycle, the assertions check the handshake holds on both ports and that no command ever carries a misaligned buffer address. They also check that the engine is silent on both ports while idle, that a start from idle is taken at once, and that done and error never rise together. Only the bench scenarios can show that whole chains produce the right sequence and contents of commands. The same holds for the stop after a bad record, for the final values of the progress registers, and for a start write during a walk leaving the chain unchanged.

// File: rtl/qdc_pkg.sv
package qdc_pkg;
  localparam int WORD_W    = 32;
  localparam int ADDR_W    = 32;
  localparam int LEN_W     = 16;
  localparam int MODE_W    = 3;
  localparam int DESC_WORDS = 3;

  typedef struct packed {
    logic [ADDR_W-1:0] data_addr;
    logic [ADDR_W-1:0] link_addr;
    logic [LEN_W-1:0]  len;
    logic              cont;
    logic [MODE_W-1:0] mode;
    logic              dir;
  } desc_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_ISSUE,
    ST_MOVE
  } walk_st_t;
endpackage

// File: rtl/qdc_fetch.sv
module qdc_fetch
  import qdc_pkg::*;
#(
  parameter int WORDS = DESC_WORDS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    go,
  input  logic [ADDR_W-1:0]       base,
  output logic                    mem_req,
  output logic [ADDR_W-1:0]       mem_addr,
  input  logic                    mem_rvalid,
  input  logic [WORD_W-1:0]       mem_rdata,
  output logic [WORDS*WORD_W-1:0] words,
  output logic                    done
);
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int STEP  = WORD_W / 8;

  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] word_q [WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
      idx      <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        mem_req  <= 1'b1;
        mem_addr <= base;
        idx      <= '0;
      end else if (mem_req && mem_rvalid) begin
        if (idx == IDX_W'(WORDS - 1)) begin
          mem_req <= 1'b0;
          done    <= 1'b1;
        end else begin
          idx      <= idx + 1'b1;
          mem_addr <= mem_addr + ADDR_W'(STEP);
        end
      end
    end
  end

  generate
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      always_ff @(posedge clk) begin
        if (!go && mem_req && mem_rvalid && idx == IDX_W'(w))
          word_q[w] <= mem_rdata;
      end
      assign words[w*WORD_W +: WORD_W] = word_q[w];
    end
  endgenerate
endmodule

// File: rtl/qdc_decode.sv
module qdc_decode
  import qdc_pkg::*;
#(
  parameter int ALIGN_BITS = 5
) (
  input  logic [DESC_WORDS*WORD_W-1:0] words,
  output desc_t                        desc,
  output logic                         misaligned
);
  logic [WORD_W-1:0] ctrl_word;
  logic              unused_ctrl;

  assign ctrl_word      = words[2*WORD_W +: WORD_W];
  assign desc.data_addr = words[0 +: ADDR_W];
  assign desc.link_addr = words[WORD_W +: ADDR_W];
  assign desc.dir       = ctrl_word[0];
  assign desc.mode      = ctrl_word[3:1];
  assign desc.cont      = ctrl_word[8];
  assign desc.len       = ctrl_word[31:16];
  assign unused_ctrl    = ^{ctrl_word[7:4], ctrl_word[15:9]};
  assign misaligned     = |desc.data_addr[ALIGN_BITS-1:0];
endmodule

// File: rtl/qdc_status.sv
module qdc_status #(
  parameter int STAT_W   = 32,
  parameter int DONE_BIT = 31,
  parameter int ERR_BIT  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_done,
  input  logic              set_err,
  input  logic [STAT_W-1:0] clr,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] nxt;

  always_comb begin
    set_vec           = '0;
    set_vec[DONE_BIT] = set_done;
    set_vec[ERR_BIT]  = set_err;
    nxt               = (status & ~clr) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= nxt;
      irq    <= |nxt;
    end
  end
endmodule

// File: rtl/desc_chain_engine.sv
module desc_chain_engine
  import qdc_pkg::*;
#(
  parameter int ALIGN_BITS = 5,
  parameter int BEAT_BYTES = 4,
  parameter int STAT_W     = 32,
  parameter int DONE_BIT   = 31,
  parameter int ERR_BIT    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_we,
  input  logic [31:0]       start_addr,
  output logic              mem_req,
  output logic [31:0]       mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [31:0]       cmd_addr,
  output logic [15:0]       cmd_len,
  output logic              cmd_dir,
  output logic [2:0]        cmd_mode,
  input  logic              mv_beat,
  input  logic              mv_done,
  output logic [31:0]       cur_desc_addr,
  output logic [31:0]       cur_mem_addr,
  output logic              busy,
  output logic [STAT_W-1:0] status,
  input  logic [STAT_W-1:0] status_clr,
  output logic              irq
);
  walk_st_t                       state;
  logic                           fetch_go;
  logic [ADDR_W-1:0]              fetch_base;
  logic [DESC_WORDS*WORD_W-1:0]   fetch_words;
  logic                           fetch_done;
  desc_t                          dec;
  logic                           dec_bad;
  logic                           cont_q;
  logic [ADDR_W-1:0]              link_q;
  logic                           set_done;
  logic                           set_err;

  assign fetch_go   = (state == ST_IDLE && start_we) ||
                      (state == ST_MOVE && mv_done && cont_q);
  assign fetch_base = (state == ST_IDLE) ? start_addr : link_q;
  assign set_err    = (state == ST_FETCH) && fetch_done && dec_bad;
  assign set_done   = (state == ST_MOVE) && mv_done && !cont_q;

  qdc_fetch #(.WORDS(DESC_WORDS)) i_fetch (
    .clk        (clk),
    .rst        (rst),
    .go         (fetch_go),
    .base       (fetch_base),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .words      (fetch_words),
    .done       (fetch_done)
  );

  qdc_decode #(.ALIGN_BITS(ALIGN_BITS)) i_decode (
    .words      (fetch_words),
    .desc       (dec),
    .misaligned (dec_bad)
  );

  qdc_status #(.STAT_W(STAT_W), .DONE_BIT(DONE_BIT), .ERR_BIT(ERR_BIT)) i_status (
    .clk      (clk),
    .rst      (rst),
    .set_done (set_done),
    .set_err  (set_err),
    .clr      (status_clr),
    .status   (status),
    .irq      (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      busy          <= 1'b0;
      cmd_valid     <= 1'b0;
      cmd_addr      <= '0;
      cmd_len       <= '0;
      cmd_dir       <= 1'b0;
      cmd_mode      <= '0;
      cur_desc_addr <= '0;
      cur_mem_addr  <= '0;
      cont_q        <= 1'b0;
      link_q        <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_we) begin
            cur_desc_addr <= start_addr;
            busy          <= 1'b1;
            state         <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (fetch_done) begin
            if (dec_bad) begin
              busy  <= 1'b0;
              state <= ST_IDLE;
            end else begin
              cmd_valid    <= 1'b1;
              cmd_addr     <= dec.data_addr;
              cmd_len      <= dec.len;
              cmd_dir      <= dec.dir;
              cmd_mode     <= dec.mode;
              cur_mem_addr <= dec.data_addr;
              cont_q       <= dec.cont;
              link_q       <= dec.link_addr;
              state        <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          if (cmd_ready) begin
            cmd_valid <= 1'b0;
            state     <= ST_MOVE;
          end
        end
        ST_MOVE: begin
          if (mv_beat)
            cur_mem_addr <= cur_mem_addr + ADDR_W'(BEAT_BYTES);
          if (mv_done) begin
            if (cont_q) begin
              cur_desc_addr <= link_q;
              state         <= ST_FETCH;
            end else begin
              busy  <= 1'b0;
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qdc_checker.sv
module qdc_checker #(
  parameter int ALIGN_BITS = 5,
  parameter int STAT_W     = 32,
  parameter int DONE_BIT   = 31,
  parameter int ERR_BIT    = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              start_we,
  input logic [31:0]       start_addr,
  input logic              mem_req,
  input logic [31:0]       mem_addr,
  input logic              mem_rvalid,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [31:0]       cmd_addr,
  input logic [15:0]       cmd_len,
  input logic              busy,
  input logic [31:0]       cur_desc_addr,
  input logic [STAT_W-1:0] status
);
  AST_CMD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_addr[ALIGN_BITS-1:0] == '0)); // R3

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_len)); // R10

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req && !cmd_valid); // R5

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
    !busy && start_we |=> busy && mem_req && cur_desc_addr == $past(start_addr)); // R1

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $rose(status[DONE_BIT]) |-> !$rose(status[ERR_BIT])); // R5
endmodule

bind desc_chain_engine qdc_checker #(
  .ALIGN_BITS (ALIGN_BITS),
  .STAT_W     (STAT_W),
  .DONE_BIT   (DONE_BIT),
  .ERR_BIT    (ERR_BIT)
) i_qdc_checker (
  .clk           (clk),
  .rst           (rst),
  .start_we      (start_we),
  .start_addr    (start_addr),
  .mem_req       (mem_req),
  .mem_addr      (mem_addr),
  .mem_rvalid    (mem_rvalid),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .cmd_addr      (cmd_addr),
  .cmd_len       (cmd_len),
  .busy          (busy),
  .cur_desc_addr (cur_desc_addr),
  .status        (status)
);

// File: tb/test_desc_chain_engine.sv
module test_desc_chain_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_we = 1'b0;
  logic [31:0] start_addr = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [31:0] cmd_addr;
  logic [15:0] cmd_len;
  logic        cmd_dir;
  logic [2:0]  cmd_mode;
  logic        mv_beat;
  logic        mv_done;
  logic [31:0] cur_desc_addr;
  logic [31:0] cur_mem_addr;
  logic        busy;
  logic [31:0] status;
  logic [31:0] status_clr = '0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  desc_chain_engine i_desc_chain_engine (
    .clk(clk), .rst(rst), .start_we(start_we), .start_addr(start_addr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .cmd_dir(cmd_dir), .cmd_mode(cmd_mode), .mv_beat(mv_beat), .mv_done(mv_done),
    .cur_desc_addr(cur_desc_addr), .cur_mem_addr(cur_mem_addr), .busy(busy),
    .status(status), .status_clr(status_clr), .irq(irq)
  );

  // record memory model: one word, one cycle after a request
  logic [31:0] mem [64];
  always @(posedge clk) begin
    if (rst) mem_rvalid <= 1'b0;
    else     mem_rvalid <= mem_req && !mem_rvalid;
    mem_rdata <= mem[mem_addr[7:2]];
  end

  // data mover stub with a command log
  logic [31:0] log_addr [16];
  logic [15:0] log_len  [16];
  logic        log_dir  [16];
  logic [2:0]  log_mode [16];
  int          n_cmds;
  int          mv_left;
  logic        done_pend;
  always @(posedge clk) begin
    if (rst) begin
      cmd_ready <= 1'b0; mv_beat <= 1'b0; mv_done <= 1'b0;
      n_cmds <= 0; mv_left <= 0; done_pend <= 1'b0;
    end else begin
      cmd_ready <= 1'b0; mv_beat <= 1'b0; mv_done <= 1'b0;
      if (mv_left > 0) begin
        mv_beat <= 1'b1;
        mv_left <= mv_left - 1;
      end else if (done_pend) begin
        mv_done   <= 1'b1;
        done_pend <= 1'b0;
      end else if (cmd_valid && !cmd_ready) begin
        cmd_ready <= 1'b1;
        log_addr[n_cmds[3:0]] <= cmd_addr;
        log_len[n_cmds[3:0]]  <= cmd_len;
        log_dir[n_cmds[3:0]]  <= cmd_dir;
        log_mode[n_cmds[3:0]] <= cmd_mode;
        n_cmds    <= n_cmds + 1;
        mv_left   <= (int'(cmd_len) + 3) / 4;
        done_pend <= 1'b1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rec_base(input int k);
    return 32'd64 + 32'(16 * k);
  endfunction
  function automatic logic [31:0] buf_addr(input int k);
    return 32'h1000 * 32'(k + 1);
  endfunction
  function automatic logic [15:0] buf_len(input int k);
    return 16'(4 * k + 5);
  endfunction

  // build n records; record bad (if < n) gets a misaligned buffer address
  task automatic build(input int n, input int bad);
    for (int k = 0; k < n; k++) begin
      mem[16 + 4*k]     = buf_addr(k) + ((k == bad) ? 32'd8 : 32'd0);
      mem[16 + 4*k + 1] = rec_base(k + 1);
      mem[16 + 4*k + 2] = {buf_len(k), 7'd0, (k < n - 1), 4'd0, 3'(k + 1), k[0]};
    end
  endtask

  task automatic kick(input logic [31:0] a);
    @(negedge clk);
    start_we = 1'b1; start_addr = a;
    @(negedge clk);
    start_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_all();
    @(negedge clk); status_clr = '1;
    @(negedge clk); status_clr = '0;
  endtask

  // vectors: upper nibble = record count, lower nibble = bad record index (F = none)
  localparam logic [7:0] VEC [4] = '{8'h1F, 8'h3F, 8'h21, 8'h30};

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 busy", {31'd0, busy}, 32'd0);
    chk("R9 irq", {31'd0, irq}, 32'd0);
    chk("R9 status", status, 32'd0);
    chk("R9 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R9 cmd_valid", {31'd0, cmd_valid}, 32'd0);
    chk("R9 cur_desc", cur_desc_addr, 32'd0);
    chk("R9 cur_mem", cur_mem_addr, 32'd0);

    for (int v = 0; v < 4; v++) begin
      int n, bad, exp_cmds, base;
      n = int'(VEC[v][7:4]);
      bad = int'(VEC[v][3:0]);
      exp_cmds = (bad < n) ? bad : n;
      build(n, bad);
      base = n_cmds;
      kick(rec_base(0));
      // R1 fetch starts at the written address
      chk("R1 busy", {31'd0, busy}, 32'd1);
      chk("R1 mem_req", {31'd0, mem_req}, 32'd1);
      chk("R1 mem_addr", mem_addr, rec_base(0));
      wait_idle();
      chk("R4 command count", 32'(n_cmds - base), 32'(exp_cmds));
      for (int k = 0; k < exp_cmds; k++) begin
        chk("R2 addr", log_addr[(base + k) % 16], buf_addr(k));
        chk("R2 len", {16'd0, log_len[(base + k) % 16]}, {16'd0, buf_len(k)});
        chk("R2 dir", {31'd0, log_dir[(base + k) % 16]}, 32'(k % 2));
        chk("R2 mode", {29'd0, log_mode[(base + k) % 16]}, 32'(k + 1));
      end
      if (bad < n) begin
        chk("R3 status error", status, 32'h0000_0008);
        chk("R3 cur_desc at bad record", cur_desc_addr, rec_base(bad));
      end else begin
        chk("R5 status done", status, 32'h8000_0000);
        chk("R4 cur_desc last record", cur_desc_addr, rec_base(n - 1));
        chk("R6 cur_mem final", cur_mem_addr,
            buf_addr(n - 1) + 32'(4 * ((int'(buf_len(n - 1)) + 3) / 4)));
      end
      chk("R8 irq set", {31'd0, irq}, 32'd1);
      chk("R5 busy low", {31'd0, busy}, 32'd0);
      clear_all();
      chk("R8 cleared", status, 32'd0);
      chk("R8 irq low", {31'd0, irq}, 32'd0);
    end

    // R7: start write during a walk is ignored
    begin
      int base;
      build(3, 15);
      base = n_cmds;
      kick(rec_base(0));
      repeat (4) @(negedge clk);
      start_we = 1'b1; start_addr = 32'h300;
      @(negedge clk);
      start_we = 1'b0;
      chk("R7 cur_desc unchanged", cur_desc_addr, rec_base(0));
      wait_idle();
      chk("R7 commands", 32'(n_cmds - base), 32'd3);
      chk("R7 cur_desc end", cur_desc_addr, rec_base(2));
      chk("R7 done", status, 32'h8000_0000);
    end

    // R8: clearing an unset bit leaves the done bit alone
    @(negedge clk); status_clr = 32'h0000_0008;
    @(negedge clk); status_clr = '0;
    chk("R8 partial clear", status, 32'h8000_0000);
    chk("R8 irq still set", {31'd0, irq}, 32'd1);
    clear_all();
    chk("R8 all cleared", status, 32'd0);

    // R6: beat counting mid-transfer on a single long record
    begin
      mem[16] = 32'h2000; mem[17] = 32'd0; mem[18] = {16'd40, 16'd0};
      kick(rec_base(0));
      for (int i = 0; i < 200 && !cmd_valid; i++) @(negedge clk);
      @(negedge clk);
      chk("R6 cur_mem load", cur_mem_addr, 32'h2000);
      wait_idle();
      chk("R6 cur_mem after beats", cur_mem_addr, 32'h2000 + 32'd40);
      clear_all();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=finish", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end
endmodule